// File: doc/BRIEF.md
# Data Access Translation and Fault Check Unit

This unit takes one data memory request per cycle and decides whether the access may proceed. If it may, the unit returns the physical address and an uncacheable attribute. If it may not, the unit returns a fault kind and a vector of status flags. The request carries the following:

- the virtual address
- the access size
- a write flag
- a flag to bypass translation
- a flag to use the alternate mode
- a flag that marks the access as a page-table-entry fetch

The processor supplies its current data mode, its alternate mode, bit 0 of the program counter and the address-space number.

A companion lookup store holds the translations. The unit presents the virtual page number and the address-space number to the store, together with a lookup strobe. It reads back the result in the same cycle: hit, physical page number, per-mode read and write enables, and the fault-on-read and fault-on-write bits. The verdict is registered, so it appears one clock after the request.

The checks run in a fixed order. The first failing check sets the result:

1. alignment
2. physical bypass
3. address canonical form
4. superpage window
5. lookup miss
6. permission, then fault-on bits
7. implemented physical width

Top module: `dxlat_unit`

## Requirements
- R1: An access whose address has any bit set under the size mask (size field s, 0..3, means 2^s bytes) gives fault code 1 (alignment) before any other check; status bit 0 (write) is set when the access is a write.
- R2: The mode used for permission checks is the current mode, except when PC bit 0 is 1. In that case it is the alternate mode if the alternate flag is set, and kernel mode otherwise. Modes are encoded kernel=0, executive=1, supervisor=2, user=3.
- R3: With the bypass flag set, the raw physical address equals the virtual address and the lookup strobe stays low.
- R4: A non-bypass address whose bits 63:47 are not all equal gives fault code 2 (page fault) with status bits 4 (bad address) and 1 (violation), plus bit 0 for a write.
- R5: An address with bits 47:41 equal to 0x7E is a superpage and never strobes the lookup. It is allowed only when the current mode (not the effective mode) is kernel. Otherwise it gives fault code 3 (violation fault) with status bit 1, plus bit 0 for a write.
- R6: A superpage physical address is the low 44 bits of the virtual address. Bits 43:40 copy bit 40 of that value.
- R7: A lookup miss gives fault code 5 when the page-table-entry-fetch flag is set and 4 otherwise. Status bit 5 (miss) is set, plus bit 0 for a write.
- R8: On a hit, the lookup strobe is high and carries virtual address bits 47:13 as the page number. The raw physical address is the physical page number shifted left by 13, with virtual address bits 12:0 below it.
- R9: A write whose write enable for the effective mode is clear gives code 2 with status bits 0 and 1, plus bit 3 if fault-on-write is set. Otherwise a set fault-on-write gives code 2 with status bits 0 and 3.
- R10: A read whose read enable for the effective mode is clear gives code 3 with status bit 1, plus bit 2 if fault-on-read is set. Otherwise a set fault-on-read gives code 2 with status bit 2.
- R11: A raw physical address with any bit at or above bit 44 gives fault code 6 (machine check) with an empty status.
- R12: An accepted address with bit 43 set is reported uncacheable, and bits 42:35 of the returned address are cleared.
- R13: The response valid follows the request valid by one clock. When the response carries a fault, or no request was made, the address and uncacheable outputs are zero. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size_lg | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Access is a write |
| req_phys | input | 1 | Bypass translation |
| req_alt | input | 1 | Use alternate mode when PC bit 0 is set |
| req_pte_fetch | input | 1 | Access fetches a page-table entry |
| cur_mode | input | 2 | Current data mode |
| alt_mode | input | 2 | Alternate mode |
| pc_lsb | input | 1 | Bit 0 of the program counter |
| cur_asn | input | 8 | Address-space number |
| tlb_req | output | 1 | Lookup strobe |
| tlb_vpn | output | 35 | Virtual page number to look up |
| tlb_asn | output | 8 | Address-space number to look up |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fon_rd | input | 1 | Fault-on-read bit |
| tlb_fon_wr | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Verdict valid |
| rsp_fault | output | 3 | Fault code, 0 for none |
| rsp_status | output | 6 | Status flag vector |
| rsp_paddr | output | 44 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |

## Verification
The assertions assume that the lookup result is valid in the same cycle as the strobe. They also assume that request inputs are stable from one sampling edge to the next, and that no request is raised while reset is held. The bench changes inputs only on the falling edge and keeps the request valid low during reset. It draws addresses from four classes: canonical low, canonical high, superpage and non-canonical. Size, mode, flags and lookup results are chosen at random, and a part of the addresses is forced to be aligned so that every later check in the order is reached.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;

    localparam int MODE_W = 2;
    localparam int NMODES = 1 << MODE_W;
    localparam int ST_W   = 6;

    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FONR  = 2;
    localparam int ST_FONW  = 3;
    localparam int ST_BADVA = 4;
    localparam int ST_MISS  = 5;

    typedef enum logic [MODE_W-1:0] {
        M_KERNEL = 2'd0,
        M_EXEC   = 2'd1,
        M_SUPER  = 2'd2,
        M_USER   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_ALIGN     = 3'd1,
        FLT_PAGE      = 3'd2,
        FLT_ACV       = 3'd3,
        FLT_MISS_DATA = 3'd4,
        FLT_MISS_PTE  = 3'd5,
        FLT_MCHECK    = 3'd6
    } fault_e;

    typedef struct packed {
        fault_e          kind;
        logic [ST_W-1:0] status;
    } verdict_t;

    function automatic logic [ST_W-1:0] st_bit(input int pos);
        logic [ST_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    function automatic logic [ST_W-1:0] st_wr(input logic is_write);
        return is_write ? st_bit(ST_WR) : '0;
    endfunction

endpackage

// File: rtl/dxlat_mode_sel.sv
module dxlat_mode_sel
    import dxlat_pkg::*;
(
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    input  logic              use_alt,
    input  logic              pc_lsb,
    output logic [MODE_W-1:0] eff_mode
);
    always_comb begin
        if (!pc_lsb)
            eff_mode = cur_mode;
        else if (use_alt)
            eff_mode = alt_mode;
        else
            eff_mode = M_KERNEL;
    end
endmodule

// File: rtl/dxlat_addr_class.sv
module dxlat_addr_class #(
    parameter int          VA_W      = 64,
    parameter int          VA_IMPL_W = 48,
    parameter int          PA_W      = 44,
    parameter int          SP_HI     = 47,
    parameter int          SP_LO     = 41,
    parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E,
    parameter int          PA_SX_BIT = 40
) (
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      size_lg,
    output logic            misaligned,
    output logic            va_bad,
    output logic            is_super,
    output logic [PA_W-1:0] super_pa
);
    localparam int UPPER_W = VA_W - VA_IMPL_W + 1;

    logic [7:0]         size_mask;
    logic [UPPER_W-1:0] upper;
    logic [PA_W-1:0]    base;

    always_comb begin
        size_mask  = (8'd1 << size_lg) - 8'd1;
        misaligned = |(va[7:0] & size_mask);
    end

    assign upper    = va[VA_W-1:VA_IMPL_W-1];
    assign va_bad   = !((&upper) || (~|upper));
    assign is_super = (va[SP_HI:SP_LO] == SP_TAG);
    assign base     = va[PA_W-1:0];

    for (genvar i = 0; i < PA_W; i++) begin : g_sx
        if (i >= PA_SX_BIT) begin : g_hi
            assign super_pa[i] = base[PA_SX_BIT];
        end else begin : g_lo
            assign super_pa[i] = base[i];
        end
    end
endmodule

// File: rtl/dxlat_perm.sv
module dxlat_perm
    import dxlat_pkg::*;
(
    input  logic              is_write,
    input  logic [MODE_W-1:0] eff_mode,
    input  logic [NMODES-1:0] rd_en,
    input  logic [NMODES-1:0] wr_en,
    input  logic              fon_rd,
    input  logic              fon_wr,
    output verdict_t          verdict
);
    always_comb begin
        verdict.kind   = FLT_NONE;
        verdict.status = '0;
        if (is_write) begin
            if (!wr_en[eff_mode]) begin
                verdict.kind   = FLT_PAGE;
                verdict.status = st_bit(ST_WR) | st_bit(ST_ACV)
                               | (fon_wr ? st_bit(ST_FONW) : '0);
            end else if (fon_wr) begin
                verdict.kind   = FLT_PAGE;
                verdict.status = st_bit(ST_WR) | st_bit(ST_FONW);
            end
        end else begin
            if (!rd_en[eff_mode]) begin
                verdict.kind   = FLT_ACV;
                verdict.status = st_bit(ST_ACV)
                               | (fon_rd ? st_bit(ST_FONR) : '0);
            end else if (fon_rd) begin
                verdict.kind   = FLT_PAGE;
                verdict.status = st_bit(ST_FONR);
            end
        end
    end
endmodule

// File: rtl/dxlat_attr.sv
module dxlat_attr #(
    parameter int RAW_W     = 64,
    parameter int PA_W      = 44,
    parameter int UC_CLR_LO = 35
) (
    input  logic [RAW_W-1:0] raw_pa,
    output logic             mcheck,
    output logic             uncached,
    output logic [PA_W-1:0]  pa
);
    assign mcheck   = |raw_pa[RAW_W-1:PA_W];
    assign uncached = raw_pa[PA_W-1];

    for (genvar i = 0; i < PA_W; i++) begin : g_clr
        if (i >= UC_CLR_LO && i < PA_W - 1) begin : g_zone
            assign pa[i] = raw_pa[i] & ~raw_pa[PA_W-1];
        end else begin : g_keep
            assign pa[i] = raw_pa[i];
        end
    end
endmodule

// File: rtl/dxlat_unit.sv
module dxlat_unit
    import dxlat_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_IMPL_W = 48,
    parameter int PA_W      = 44,
    parameter int PAGE_BITS = 13,
    parameter int PPN_W     = 32,
    parameter int ASN_W     = 8,
    parameter int UC_CLR_LO = 35,
    parameter int PA_SX_BIT = 40,
    localparam int VPN_W    = VA_IMPL_W - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_va,
    input  logic [1:0]           req_size_lg,
    input  logic                 req_write,
    input  logic                 req_phys,
    input  logic                 req_alt,
    input  logic                 req_pte_fetch,
    input  logic [1:0]           cur_mode,
    input  logic [1:0]           alt_mode,
    input  logic                 pc_lsb,
    input  logic [ASN_W-1:0]     cur_asn,
    output logic                 tlb_req,
    output logic [VPN_W-1:0]     tlb_vpn,
    output logic [ASN_W-1:0]     tlb_asn,
    input  logic                 tlb_hit,
    input  logic [PPN_W-1:0]     tlb_ppn,
    input  logic [3:0]           tlb_rd_en,
    input  logic [3:0]           tlb_wr_en,
    input  logic                 tlb_fon_rd,
    input  logic                 tlb_fon_wr,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_fault,
    output logic [ST_W-1:0]      rsp_status,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic                 rsp_uncached
);
    localparam int RAW_W = VA_W;

    logic [MODE_W-1:0] eff_mode;
    logic              misaligned, va_bad, is_super;
    logic [PA_W-1:0]   super_pa;
    verdict_t          perm_v;
    logic [RAW_W-1:0]  raw_pa;
    logic              mcheck, uncached;
    logic [PA_W-1:0]   attr_pa;
    verdict_t          nxt_v;
    logic              need_lookup;
    logic              pa_ok;

    dxlat_mode_sel u_mode (
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .use_alt  (req_alt),
        .pc_lsb   (pc_lsb),
        .eff_mode (eff_mode)
    );

    dxlat_addr_class #(
        .VA_W      (VA_W),
        .VA_IMPL_W (VA_IMPL_W),
        .PA_W      (PA_W),
        .PA_SX_BIT (PA_SX_BIT)
    ) u_class (
        .va         (req_va),
        .size_lg    (req_size_lg),
        .misaligned (misaligned),
        .va_bad     (va_bad),
        .is_super   (is_super),
        .super_pa   (super_pa)
    );

    dxlat_perm u_perm (
        .is_write (req_write),
        .eff_mode (eff_mode),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .fon_rd   (tlb_fon_rd),
        .fon_wr   (tlb_fon_wr),
        .verdict  (perm_v)
    );

    dxlat_attr #(
        .RAW_W     (RAW_W),
        .PA_W      (PA_W),
        .UC_CLR_LO (UC_CLR_LO)
    ) u_attr (
        .raw_pa   (raw_pa),
        .mcheck   (mcheck),
        .uncached (uncached),
        .pa       (attr_pa)
    );

    // Ordered check chain; the first failing stage sets the verdict.
    always_comb begin
        nxt_v.kind   = FLT_NONE;
        nxt_v.status = '0;
        raw_pa       = '0;
        need_lookup  = 1'b0;
        if (misaligned) begin
            nxt_v.kind   = FLT_ALIGN;
            nxt_v.status = st_wr(req_write);
        end else if (req_phys) begin
            raw_pa = req_va;
        end else if (va_bad) begin
            nxt_v.kind   = FLT_PAGE;
            nxt_v.status = st_wr(req_write) | st_bit(ST_BADVA) | st_bit(ST_ACV);
        end else if (is_super) begin
            if (cur_mode != M_KERNEL) begin
                nxt_v.kind   = FLT_ACV;
                nxt_v.status = st_wr(req_write) | st_bit(ST_ACV);
            end else begin
                raw_pa = RAW_W'(super_pa);
            end
        end else begin
            need_lookup = 1'b1;
            if (!tlb_hit) begin
                nxt_v.kind   = req_pte_fetch ? FLT_MISS_PTE : FLT_MISS_DATA;
                nxt_v.status = st_wr(req_write) | st_bit(ST_MISS);
            end else begin
                raw_pa = RAW_W'({tlb_ppn, req_va[PAGE_BITS-1:0]});
                nxt_v  = perm_v;
            end
        end
        if (nxt_v.kind == FLT_NONE && mcheck) begin
            nxt_v.kind   = FLT_MCHECK;
            nxt_v.status = '0;
        end
    end

    assign pa_ok   = req_valid && (nxt_v.kind == FLT_NONE);
    assign tlb_req = req_valid && need_lookup;
    assign tlb_vpn = req_va[VA_IMPL_W-1:PAGE_BITS];
    assign tlb_asn = cur_asn;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= FLT_NONE;
            rsp_status   <= '0;
            rsp_paddr    <= '0;
            rsp_uncached <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_fault    <= req_valid ? nxt_v.kind : FLT_NONE;
            rsp_status   <= req_valid ? nxt_v.status : '0;
            rsp_paddr    <= pa_ok ? attr_pa : '0;
            rsp_uncached <= pa_ok && uncached;
        end
    end
endmodule

// File: rtl/dxlat_chk.sv
module dxlat_chk #(
    parameter int PA_W      = 44,
    parameter int UC_CLR_LO = 35
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [63:0]     req_va,
    input logic [1:0]      req_size_lg,
    input logic            req_phys,
    input logic            tlb_req,
    input logic            rsp_valid,
    input logic [2:0]      rsp_fault,
    input logic [5:0]      rsp_status,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_uncached
);
    logic [7:0] cmask;
    logic       in_super;
    assign cmask    = (8'd1 << req_size_lg) - 8'd1;
    assign in_super = (&req_va[63:47]) && (req_va[47:41] == 7'h7E);

    a_r1_align_first: assert property (@(posedge clk) disable iff (rst)
        req_valid && ((req_va[7:0] & cmask) != 8'd0) |=> rsp_fault == 3'd1);

    a_r3_bypass_no_lookup: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_phys |-> !tlb_req);

    a_r5_super_no_lookup: assert property (@(posedge clk) disable iff (rst)
        req_valid && in_super |-> !tlb_req);

    a_r7_miss_flags: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5)
        |-> rsp_status[5] && !rsp_status[1] && !rsp_status[4]);

    a_r12_uncached_zone: assert property (@(posedge clk) disable iff (rst)
        rsp_uncached |-> rsp_paddr[PA_W-1] && (rsp_paddr[PA_W-2:UC_CLR_LO] == '0));

    a_r13_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rsp_valid == $past(req_valid && !rst));

    a_r13_fault_clean: assert property (@(posedge clk) disable iff (rst)
        rsp_fault != 3'd0 |-> rsp_paddr == '0 && !rsp_uncached);
endmodule

bind dxlat_unit dxlat_chk #(.PA_W(PA_W), .UC_CLR_LO(UC_CLR_LO)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .req_size_lg  (req_size_lg),
    .req_phys     (req_phys),
    .tlb_req      (tlb_req),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_status   (rsp_status),
    .rsp_paddr    (rsp_paddr),
    .rsp_uncached (rsp_uncached)
);

// File: tb/dxlat_unit_test.sv
`timescale 1ns/1ps
module dxlat_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_phys, req_alt, req_pte_fetch, pc_lsb;
    logic [63:0] req_va;
    logic [1:0]  req_size_lg, cur_mode, alt_mode;
    logic [7:0]  cur_asn;
    logic        tlb_req;
    logic [34:0] tlb_vpn;
    logic [7:0]  tlb_asn;
    logic        tlb_hit, tlb_fon_rd, tlb_fon_wr;
    logic [31:0] tlb_ppn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic        rsp_valid, rsp_uncached;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_status;
    logic [43:0] rsp_paddr;

    int vectors = 0;
    int misses  = 0;

    always #2.5 clk = ~clk;

    dxlat_unit uut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent reference derived from the requirement text.
    task automatic expect_of(output logic [2:0] f, output logic [5:0] st,
                             output logic [43:0] pa, output logic uc,
                             output logic lk, output string tag);
        logic [1:0]  em;
        logic [63:0] raw, m;
        logic [43:0] b;
        em  = pc_lsb ? (req_alt ? alt_mode : 2'd0) : cur_mode;
        f = 0; st = 0; pa = 0; uc = 0; lk = 0; raw = 0; tag = "R8";
        m = (64'd1 << req_size_lg) - 1;
        if ((req_va & m) != 0) begin
            f = 1; st = {5'd0, req_write}; tag = "R1";
        end else if (req_phys) begin
            raw = req_va; tag = "R3";
        end else if (!(req_va[63:47] == '0 || req_va[63:47] == '1)) begin
            f = 2; st = 6'h12 | {5'd0, req_write}; tag = "R4";
        end else if (req_va[47:41] == 7'h7E) begin
            if (cur_mode != 0) begin
                f = 3; st = 6'h02 | {5'd0, req_write}; tag = "R5";
            end else begin
                b = req_va[43:0];
                raw = {20'd0, {4{b[40]}}, b[39:0]}; tag = "R6";
            end
        end else begin
            lk = 1;
            if (!tlb_hit) begin
                f = req_pte_fetch ? 3'd5 : 3'd4; st = 6'h20 | {5'd0, req_write}; tag = "R7";
            end else begin
                raw = ({32'd0, tlb_ppn} << 13) | {51'd0, req_va[12:0]};
                if (req_write) begin
                    if (!tlb_wr_en[em]) begin
                        f = 2; st = 6'h03 | (tlb_fon_wr ? 6'h08 : 6'h00); tag = "R9";
                    end else if (tlb_fon_wr) begin
                        f = 2; st = 6'h09; tag = "R9";
                    end
                end else begin
                    if (!tlb_rd_en[em]) begin
                        f = 3; st = 6'h02 | (tlb_fon_rd ? 6'h04 : 6'h00); tag = "R10";
                    end else if (tlb_fon_rd) begin
                        f = 2; st = 6'h04; tag = "R10";
                    end
                end
                if (pc_lsb && (tag == "R9" || tag == "R10")) tag = "R2";
            end
        end
        if (f == 0) begin
            if (raw[63:44] != 0) begin
                f = 6; st = 0; tag = "R11";
            end else begin
                pa = raw[43:0];
                if (pa[43]) begin
                    uc = 1; pa[42:35] = 8'd0; tag = "R12";
                end
            end
        end
    endtask

    task automatic apply_and_check();
        logic [2:0] f; logic [5:0] st; logic [43:0] pa; logic uc, lk; string tag;
        expect_of(f, st, pa, uc, lk, tag);
        req_valid = 1'b1;
        #1;
        check(req_phys ? "R3 strobe" : (lk ? "R8 strobe" : "R5 strobe"), {63'd0, tlb_req}, {63'd0, lk});
        if (lk) check("R8 vpn", {29'd0, tlb_vpn}, {29'd0, req_va[47:13]});
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " fault"}, {61'd0, rsp_fault}, {61'd0, f});
        check({tag, " status"}, {58'd0, rsp_status}, {58'd0, st});
        check({tag, " paddr"}, {20'd0, rsp_paddr}, {20'd0, pa});
        check({tag, " uncached"}, {63'd0, rsp_uncached}, {63'd0, uc});
        check("R13 valid", {63'd0, rsp_valid}, 64'd1);
    endtask

    function automatic logic [63:0] pick_va(input int cls);
        logic [63:0] v;
        v = {$urandom, $urandom};
        case (cls)
            0: v[63:47] = '0;
            1: begin v[63:48] = '1; v[47:41] = 7'h7E; end
            2: v[63:47] = 17'h0A5A5;
            default: begin v[63:47] = '1; if (v[47:41] == 7'h7E) v[41] = 1'b0; end
        endcase
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        misses++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
        rst = 1; req_valid = 0; req_va = 0; req_size_lg = 0; req_write = 0;
        req_phys = 0; req_alt = 0; req_pte_fetch = 0; cur_mode = 0; alt_mode = 0;
        pc_lsb = 0; cur_asn = 0; tlb_hit = 0; tlb_ppn = 0; tlb_rd_en = 0;
        tlb_wr_en = 0; tlb_fon_rd = 0; tlb_fon_wr = 0;
        repeat (3) @(negedge clk);
        check("R13 reset valid", {63'd0, rsp_valid}, 64'd0);
        check("R13 reset fault", {61'd0, rsp_fault}, 64'd0);
        rst = 0;
        @(negedge clk);
        check("R13 idle", {63'd0, rsp_valid}, 64'd0);

        // Directed: superpage sign extension both ways, bypass uncached.
        req_va = 64'hFFFF_FD00_0000_1238; req_size_lg = 3; apply_and_check();  // R6 bit40=1
        req_va = 64'hFFFF_FC80_0000_1238; apply_and_check();                   // R6 bit40=0
        req_phys = 1; req_va = 64'h0000_0FFF_FFFF_FFF0; apply_and_check();      // R12
        req_va = 64'h0000_1000_0000_0000; apply_and_check();                    // R11
        req_phys = 0;

        // Sweep of alignment over size and low bits (R1).
        for (int s = 0; s < 4; s++) begin
            for (int lo = 0; lo < 8; lo++) begin
                req_size_lg = s[1:0]; req_va = {61'd0, lo[2:0]};
                req_write = lo[0]; apply_and_check();
            end
        end

        // Effective-mode sweep (R2) over all mode combinations with single-bit enables.
        for (int pm = 0; pm < 32; pm++) begin
            for (int en = 0; en < 4; en++) begin
                req_va = 64'h0000_0000_0040_2000; req_size_lg = 0; req_phys = 0;
                cur_mode = pm[1:0]; alt_mode = pm[3:2]; req_alt = pm[4]; pc_lsb = en[1];
                tlb_hit = 1; tlb_ppn = 32'h0000_1234; tlb_rd_en = 4'b1 << (pm[1:0] ^ en[1:0]);
                tlb_wr_en = tlb_rd_en; req_write = en[0]; tlb_fon_rd = 0; tlb_fon_wr = 0;
                apply_and_check();
            end
        end

        for (int n = 0; n < 3000; n++) begin
            req_va        = pick_va($urandom % 4);
            req_size_lg   = 2'($urandom);
            if ($urandom % 4 != 0) req_va[2:0] = 3'd0;
            req_write     = 1'($urandom);
            req_phys      = ($urandom % 6 == 0);
            if (req_phys && $urandom % 3 != 0) req_va[63:44] = '0;
            req_alt       = 1'($urandom);
            req_pte_fetch = 1'($urandom);
            cur_mode      = 2'($urandom);
            if ($urandom % 2 == 0) cur_mode = 2'd0;
            alt_mode      = 2'($urandom);
            pc_lsb        = 1'($urandom);
            cur_asn       = 8'($urandom);
            tlb_hit       = ($urandom % 4 != 0);
            tlb_ppn       = $urandom;
            if ($urandom % 4 != 0) tlb_ppn[31] = 1'b0;
            tlb_rd_en     = 4'($urandom);
            tlb_wr_en     = 4'($urandom);
            tlb_fon_rd    = ($urandom % 5 == 0);
            tlb_fon_wr    = ($urandom % 5 == 0);
            apply_and_check();
            check("R8 asn", {56'd0, tlb_asn}, {56'd0, cur_asn});
        end

        @(negedge clk);
        check("R13 idle after", {63'd0, rsp_valid}, 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule